// File: doc/BRIEF.md
# Double-Data-Rate Byte-Lane Data Path

This block sits between a memory controller core and the pads of one strobe group of a double-data-rate memory. On the write side, the core raises a start request and then supplies one double-width word (and its byte masks) per clock. The block drives each word out as two half-clock beats: the low half while the core clock is high and the high half while it is low. It also drives a strobe taken from a quarter-phase clock, so that every strobe edge falls in the middle of a data beat. A single output enable covers the data, mask and strobe drivers. It rises one clock before the first beat, which is the strobe preamble, and it falls one clock after the last beat, which is the postamble.

On the read side, the block receives a copy of the memory's strobe that has already been delayed. A rising edge of that strobe captures the first beat and the following falling edge captures the second beat. The two beats are joined into a double-width word, and a toggle output flips once for every word captured. Strobe edges count only while the controller holds the read window open. A read window also takes priority over writing: it turns the output enable off and ends any burst that is in progress.

Top module: `ddr_byte_lane`

## Requirements
- R1: During reset and in the first clock after it, oe_o, dq_o, dm_o, dqs_o, rd_data and rd_tgl are all zero.
- R2: A write starts when wr_start is sampled high while the lane is idle and rd_en is low. In the clock that follows the accepting edge (the preamble), oe_o is 1 while dqs_o stays 0 and dq_o is 0.
- R3: wr_data is sampled at each of the BURST_LEN edges that follow the accepting edge. In the clock after each of these edges, dq_o carries wr_data[LANE_W-1:0] while clk is high and wr_data[2*LANE_W-1:LANE_W] while clk is low.
- R4: During every burst clock, dqs_o follows clk90, the clock delayed by a quarter period. Its rising edge therefore sits in the middle of the low beat and its falling edge in the middle of the high beat. dqs_o is 0 in the preamble and postamble clocks and whenever the lane is not writing.
- R5: dm_o has one bit per 8-bit data byte, and a 1 means the byte is masked. It uses the same timing as dq_o: wr_mask[M-1:0] applies while clk is high and wr_mask[2M-1:M] while clk is low, with bit j covering dq_o[8j+7:8j].
- R6: oe_o stays high for exactly BURST_LEN+2 clocks, including one postamble clock in which dq_o and dqs_o are 0. A wr_start raised while a write is in progress is ignored.
- R7: When rd_en is sampled high, oe_o is 0 in the following clock and any write in progress is abandoned. wr_start has no effect while rd_en is high.
- R8: While rd_en is high, a rising edge of dqs_dly_i captures dq_i as the low half of the read word. The next falling edge captures dq_i as the high half, loads rd_data with {high, low} and inverts rd_tgl.
- R9: Edges on dqs_dly_i while rd_en is low leave rd_data and rd_tgl unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; its level selects the beat |
| clk90 | input | 1 | Core clock delayed by a quarter period, used for the write strobe |
| rst | input | 1 | Synchronous active-high reset (the read capture registers reset asynchronously) |
| wr_start | input | 1 | Request to begin a write burst |
| wr_data | input | 2*LANE_W | Double-width write word |
| wr_mask | input | 2*LANE_W/8 | Byte masks for the two beats, 1 = masked |
| rd_en | input | 1 | Read window open |
| dq_i | input | LANE_W | Data from the pads |
| dqs_dly_i | input | 1 | Delayed incoming strobe |
| dq_o | output | LANE_W | Data to the pads |
| dm_o | output | LANE_W/8 | Mask to the pads |
| dqs_o | output | 1 | Strobe to the pads |
| oe_o | output | 1 | Output enable for the data, mask and strobe drivers |
| rd_data | output | 2*LANE_W | Last captured read word |
| rd_tgl | output | 1 | Flips once per captured read word |

## Verification
The output enable changes one clock after the edge that samples wr_start or rd_en. Each write word appears at the pins in the clock after the edge that samples it, with the low beat in the first half of that clock and the high beat in the second half. The strobe is high only from one quarter to three quarters of each burst clock. The bench therefore samples 1 ns after a rising clock edge for the enable and the low beat, at 3 ns and 7 ns for the strobe level, and at 5 ns for the high beat. Read words are checked a short time after the falling strobe edge that completes them, because capture needs no core-clock edge at all.

// File: rtl/ddr_lane_pkg.sv
`timescale 1ns/1ps
package ddr_lane_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_PRE   = 2'd1,
    WS_BURST = 2'd2,
    WS_POST  = 2'd3
  } wr_state_e;

  function automatic int mask_width(input int lane_w, input int grain);
    return (lane_w + grain - 1) / grain;
  endfunction

endpackage

// File: rtl/ddr_wr_seq.sv
`timescale 1ns/1ps
module ddr_wr_seq #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_start,
  input  logic rd_en,
  output logic oe_o,
  output logic strobe_en_o,
  output logic load_o
);
  import ddr_lane_pkg::*;

  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

  wr_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oe_q, strobe_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      WS_IDLE: begin
        if (wr_start && !rd_en) begin
          st_d  = WS_PRE;
          cnt_d = '0;
        end
      end
      WS_PRE: begin
        st_d = rd_en ? WS_IDLE : WS_BURST;
      end
      WS_BURST: begin
        if (rd_en) begin
          st_d = WS_IDLE;
        end else if (cnt_q == LAST_BEAT) begin
          st_d = WS_POST;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      WS_POST: begin
        st_d = WS_IDLE;
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= WS_IDLE;
      cnt_q    <= '0;
      oe_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      oe_q     <= (st_d != WS_IDLE);
      strobe_q <= (st_d == WS_BURST);
    end
  end

  assign load_o      = (st_d == WS_BURST) && !rst;
  assign oe_o        = oe_q;
  assign strobe_en_o = strobe_q;

endmodule

// File: rtl/ddr_tx_lane.sv
`timescale 1ns/1ps
module ddr_tx_lane #(
  parameter int LANE_W = 8,
  parameter int GRAIN  = 8
) (
  input  logic                  clk,
  input  logic                  clk90,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  strobe_en,
  input  logic [2*LANE_W-1:0]   wr_data,
  input  logic [2*(LANE_W/GRAIN)-1:0] wr_mask,
  output logic [LANE_W-1:0]     dq_o,
  output logic [LANE_W/GRAIN-1:0] dm_o,
  output logic                  dqs_o
);
  localparam int M = LANE_W / GRAIN;

  logic [2*LANE_W-1:0] word_q;
  logic [2*M-1:0]      mask_q;

  always_ff @(posedge clk) begin
    if (rst || !load) begin
      word_q <= '0;
      mask_q <= '0;
    end else begin
      word_q <= wr_data;
      mask_q <= wr_mask;
    end
  end

  for (genvar g = 0; g < M; g++) begin : g_byte
    assign dq_o[g*GRAIN +: GRAIN] = clk ? word_q[g*GRAIN +: GRAIN]
                                        : word_q[LANE_W + g*GRAIN +: GRAIN];
    assign dm_o[g] = clk ? mask_q[g] : mask_q[M + g];
  end

  assign dqs_o = strobe_en & clk90;

endmodule

// File: rtl/ddr_rx_capture.sv
`timescale 1ns/1ps
module ddr_rx_capture #(
  parameter int LANE_W = 8
) (
  input  logic                rst,
  input  logic                rd_en,
  input  logic                dqs_dly_i,
  input  logic [LANE_W-1:0]   dq_i,
  output logic [2*LANE_W-1:0] rd_data,
  output logic                rd_tgl
);
  logic [LANE_W-1:0]   lo_q;
  logic [2*LANE_W-1:0] word_q;
  logic                tgl_q;

  always_ff @(posedge dqs_dly_i or posedge rst) begin
    if (rst) begin
      lo_q <= '0;
    end else if (rd_en) begin
      lo_q <= dq_i;
    end
  end

  always_ff @(negedge dqs_dly_i or posedge rst) begin
    if (rst) begin
      word_q <= '0;
      tgl_q  <= 1'b0;
    end else if (rd_en) begin
      word_q <= {dq_i, lo_q};
      tgl_q  <= ~tgl_q;
    end
  end

  assign rd_data = word_q;
  assign rd_tgl  = tgl_q;

endmodule

// File: rtl/ddr_byte_lane.sv
`timescale 1ns/1ps
module ddr_byte_lane #(
  parameter int LANE_W    = 8,
  parameter int BURST_LEN = 4,
  parameter int GRAIN     = 8
) (
  input  logic                      clk,
  input  logic                      clk90,
  input  logic                      rst,
  input  logic                      wr_start,
  input  logic [2*LANE_W-1:0]       wr_data,
  input  logic [2*(LANE_W/GRAIN)-1:0] wr_mask,
  input  logic                      rd_en,
  input  logic [LANE_W-1:0]         dq_i,
  input  logic                      dqs_dly_i,
  output logic [LANE_W-1:0]         dq_o,
  output logic [LANE_W/GRAIN-1:0]   dm_o,
  output logic                      dqs_o,
  output logic                      oe_o,
  output logic [2*LANE_W-1:0]       rd_data,
  output logic                      rd_tgl
);
  logic burst_on;
  logic load_word;

  ddr_wr_seq #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_start    (wr_start),
    .rd_en       (rd_en),
    .oe_o        (oe_o),
    .strobe_en_o (burst_on),
    .load_o      (load_word)
  );

  ddr_tx_lane #(.LANE_W(LANE_W), .GRAIN(GRAIN)) u_tx (
    .clk       (clk),
    .clk90     (clk90),
    .rst       (rst),
    .load      (load_word),
    .strobe_en (burst_on),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .dq_o      (dq_o),
    .dm_o      (dm_o),
    .dqs_o     (dqs_o)
  );

  ddr_rx_capture #(.LANE_W(LANE_W)) u_rx (
    .rst       (rst),
    .rd_en     (rd_en),
    .dqs_dly_i (dqs_dly_i),
    .dq_i      (dq_i),
    .rd_data   (rd_data),
    .rd_tgl    (rd_tgl)
  );

endmodule

// File: rtl/ddr_byte_lane_chk.sv
`timescale 1ns/1ps
module ddr_byte_lane_chk #(
  parameter int BURST_LEN = 4
) (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic oe_o,
  input logic strobe_en
);
  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (oe_o) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  a_r7_read_drops_oe: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !oe_o);

  a_r6_window_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe_o) && !$past(rd_en)) |-> (run_q == 16'(BURST_LEN + 2)));

  a_r2_preamble_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> !strobe_en);

  a_r2_burst_follows: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_o) && !rd_en) |=> strobe_en);

  a_r4_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
    strobe_en |-> oe_o);

endmodule

bind ddr_byte_lane ddr_byte_lane_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .oe_o      (oe_o),
  .strobe_en (burst_on)
);

// File: tb/sim_ddr_byte_lane.sv
`timescale 1ns/1ps
module sim_ddr_byte_lane;
  localparam int W  = 8;
  localparam int BL = 4;
  localparam int M  = 1;

  logic clk, clk90, rst, wr_start, rd_en, dqs_dly_i;
  logic [2*W-1:0] wr_data;
  logic [2*M-1:0] wr_mask;
  logic [W-1:0]   dq_i, dq_o;
  logic [M-1:0]   dm_o;
  logic           dqs_o, oe_o, rd_tgl;
  logic [2*W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  ddr_byte_lane #(.LANE_W(W), .BURST_LEN(BL), .GRAIN(8)) u0 (
    .clk(clk), .clk90(clk90), .rst(rst), .wr_start(wr_start),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_en(rd_en), .dq_i(dq_i),
    .dqs_dly_i(dqs_dly_i), .dq_o(dq_o), .dm_o(dm_o), .dqs_o(dqs_o),
    .oe_o(oe_o), .rd_data(rd_data), .rd_tgl(rd_tgl)
  );

  // {mask_hi, mask_lo, data_hi, data_lo}
  localparam logic [2*M+2*W-1:0] WVEC [8] = '{
    {2'b00, 16'hA55A}, {2'b01, 16'h0FF0}, {2'b10, 16'h1234}, {2'b11, 16'hFFFF},
    {2'b00, 16'h0000}, {2'b10, 16'h8001}, {2'b01, 16'hC3E7}, {2'b00, 16'h7E81}
  };

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    clk90 = 1'b0;
    #6;
    forever begin
      clk90 = ~clk90;
      #4;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic write_burst(input int base, input bit poke_start);
    @(posedge clk); #1 wr_start = 1'b1;
    @(posedge clk); #1;
    wr_start = 1'b0;
    wr_data  = WVEC[base][2*W-1:0];
    wr_mask  = WVEC[base][2*W +: 2*M];
    chk("R2 preamble oe", 32'(oe_o), 32'd1);
    chk("R2 preamble dq", 32'(dq_o), 32'd0);
    #2 chk("R4 preamble strobe low", 32'(dqs_o), 32'd0);
    for (int k = 0; k < BL; k++) begin
      @(posedge clk); #1;
      if (k + 1 < BL) begin
        wr_data = WVEC[base+k+1][2*W-1:0];
        wr_mask = WVEC[base+k+1][2*W +: 2*M];
      end
      if (poke_start) wr_start = (k == 1);
      chk("R6 burst oe", 32'(oe_o), 32'd1);
      chk("R3 low beat", 32'(dq_o), 32'(WVEC[base+k][W-1:0]));
      chk("R5 low mask", 32'(dm_o), 32'(WVEC[base+k][2*W +: M]));
      #2 chk("R4 strobe high mid", 32'(dqs_o), 32'd1);
      #2;
      chk("R3 high beat", 32'(dq_o), 32'(WVEC[base+k][2*W-1:W]));
      chk("R5 high mask", 32'(dm_o), 32'(WVEC[base+k][2*W+M +: M]));
      #2 chk("R4 strobe low late", 32'(dqs_o), 32'd0);
    end
    wr_start = 1'b0;
    @(posedge clk); #1;
    chk("R6 postamble oe", 32'(oe_o), 32'd1);
    chk("R6 postamble dq", 32'(dq_o), 32'd0);
    #2 chk("R4 postamble strobe", 32'(dqs_o), 32'd0);
    @(posedge clk); #1;
    chk("R6 window closed", 32'(oe_o), 32'd0);
  endtask

  task automatic read_pair(input logic [W-1:0] lo, input logic [W-1:0] hi);
    dq_i = lo; #1 dqs_dly_i = 1'b1;
    #1 dq_i = hi; #1 dqs_dly_i = 1'b0;
    #1;
  endtask

  initial begin
    rst = 1'b1; wr_start = 1'b0; rd_en = 1'b0; dqs_dly_i = 1'b0;
    wr_data = '0; wr_mask = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 reset oe", 32'(oe_o), 32'd0);
    chk("R1 reset dqs", 32'(dqs_o), 32'd0);
    chk("R1 reset dq", 32'(dq_o), 32'd0);
    chk("R1 reset dm", 32'(dm_o), 32'd0);
    chk("R1 reset rd_data", 32'(rd_data), 32'd0);
    chk("R1 reset rd_tgl", 32'(rd_tgl), 32'd0);
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #1 chk("R1 after reset oe", 32'(oe_o), 32'd0);

    // table-driven write bursts
    for (int b = 0; b < 2; b++) begin
      write_burst(b * BL, b == 0);  // R6: first burst pokes wr_start mid-burst
    end

    // R7: read window abandons a write in progress
    @(posedge clk); #1 wr_start = 1'b1;
    @(posedge clk); #1 wr_start = 1'b0; wr_data = 16'h5AA5;
    @(posedge clk); #1 rd_en = 1'b1;
    chk("R7 burst running before read", 32'(oe_o), 32'd1);
    @(posedge clk); #1 chk("R7 oe off after read", 32'(oe_o), 32'd0);
    #2 chk("R7 strobe off after read", 32'(dqs_o), 32'd0);
    #2;
    wr_start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 chk("R7 start ignored in read", 32'(oe_o), 32'd0);
    end
    wr_start = 1'b0;

    // R8: read capture with rd_en high
    read_pair(8'h3C, 8'hC3);
    chk("R8 read word 0", 32'(rd_data), 32'hC33C);
    chk("R8 toggle 0", 32'(rd_tgl), 32'd1);
    read_pair(8'h01, 8'hFE);
    chk("R8 read word 1", 32'(rd_data), 32'hFE01);
    chk("R8 toggle 1", 32'(rd_tgl), 32'd0);

    // R9: strobe edges with read window closed
    @(posedge clk); #1 rd_en = 1'b0;
    read_pair(8'h77, 8'h99);
    chk("R9 rd_data held", 32'(rd_data), 32'hFE01);
    chk("R9 rd_tgl held", 32'(rd_tgl), 32'd0);
    @(posedge clk); #1 chk("R9 lane idle", 32'(oe_o), 32'd0);

    // write works again after reading
    write_burst(BL, 1'b0);

    finish_run();
  end

endmodule